// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor core and decides, at each instruction boundary, whether an interrupt should be taken and which one. It has five request inputs. The first is a non-maskable input that needs both an edge and a level. The second is a maskable input that is latched on its rising edge. The third and fourth are two maskable inputs that act on their level. The fifth is a general maskable input that acts on its level and has no vector of its own. The block holds a global enable flag, one mask bit for each vectored maskable source, and the edge latches. From these it computes one qualified request per source.

When the core raises the boundary strobe, the block registers the winning source as a one-hot select and registers its fixed 16-bit vector. The core then returns an acknowledge with the same one-hot select. The acknowledge clears the matching latch and the global enable. The core also issues enable, disable and mask-load commands. Stacking the program counter and fetching the handler are left to the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, `irq_valid` is 0, `irq_src` is 0 and `ie_flag` is 0. All three mask bits are set, so a maskable source gives no request until the masks are loaded again.
- R2: The non-maskable source requests only if a rising edge of `nmi_in` has been latched and `nmi_in` is still high when the boundary strobe samples it. A pulse that has already fallen gives no request. This source ignores the masks and `ie_flag`.
- R3: Acknowledging the non-maskable source (`irq_src` bit 4) clears its latch. While `nmi_in` stays high, no new request appears; one appears only after the input goes low and then high again.
- R4: A rising edge on `edge_in` is remembered as pending after the input falls. Acknowledging that source (`irq_src` bit 3) clears the pending latch.
- R5: A mask load (`msk_wr`) with `msk_clr_edge` high clears the pending `edge_in` latch. A mask load with `msk_clr_edge` low leaves the latch as it was.
- R6: The `lvl_in` inputs are not latched. A level request that drops before the boundary strobe gives no request.
- R7: A vectored maskable source requests only when its input is pending, its mask bit is 0 and `ie_flag` is 1. The `msk_data` bits map as follows: bit 2 masks `edge_in`, bit 1 masks `lvl_in[1]` and bit 0 masks `lvl_in[0]`.
- R8: The priority runs from highest to lowest: non-maskable, `edge_in`, `lvl_in[1]`, `lvl_in[0]`, `gen_in`. `irq_src` is one-hot with bit 4 = non-maskable, bit 3 = `edge_in`, bit 2 = `lvl_in[1]`, bit 1 = `lvl_in[0]` and bit 0 = `gen_in`.
- R9: `irq_vec` is 0x0054 for the non-maskable source, 0x003C for `edge_in`, 0x0034 for `lvl_in[1]` and 0x002C for `lvl_in[0]`.
- R10: `ie_flag` is set by `ei_cmd`. It is cleared by `di_cmd` and by any acknowledge. When a clear and `ei_cmd` arrive in the same cycle, the clear wins.
- R11: `gen_in` requests on a high level whenever `ie_flag` is 1, whatever the masks hold. When it wins, `irq_has_vec` is 0 and `irq_vec` is 0.
- R12: The outputs are loaded only on a cycle with `boundary` high and hold between strobes. An acknowledge drops `irq_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, edge plus level |
| edge_in | input | 1 | Highest maskable request, rising-edge latched |
| lvl_in | input | 2 | Level-sensitive maskable requests, bit 1 higher |
| gen_in | input | 1 | General maskable level request, no vector |
| boundary | input | 1 | Instruction-boundary sampling strobe |
| ack | input | 1 | Acknowledge from the core |
| ack_sel | input | 5 | One-hot source being acknowledged |
| ei_cmd | input | 1 | Enable-interrupt command |
| di_cmd | input | 1 | Disable-interrupt command |
| msk_wr | input | 1 | Mask-load command |
| msk_data | input | 3 | New mask bits |
| msk_clr_edge | input | 1 | With msk_wr, clears the edge_in latch |
| irq_valid | output | 1 | A request was selected at the last strobe |
| irq_src | output | 5 | One-hot winning source |
| irq_vec | output | 16 | Vector of the winning source |
| irq_has_vec | output | 1 | Winner supplies a vector |
| ie_flag | output | 1 | Global enable state |

## Verification
The bench sends a non-maskable pulse that has fallen by the time the strobe samples it. A design that checks only the edge would take that noise as a request. It then holds the non-maskable input high across an acknowledge. A design that re-arms on the level would then fire again at once. It lets the edge input fall before the strobe, then clears the edge latch through a mask load with and without the clear bit. This exposes a design that drops the latch early, or one that ignores the clear bit, or one that clears on every mask load. It also issues enable in the same cycle as a disable or an acknowledge. With all sources active it walks down the priority ladder one step at a time, where a swapped pair or a wrong vector shows up directly.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned NMI_VECTOR = 32'h0054;
  localparam int unsigned MSK_VEC_BASE = 32'h002C;
  localparam int unsigned MSK_VEC_STEP = 32'h0008;

  // Vector of source index i; index 0 is the general source, nsrc-1 the non-maskable one.
  function automatic logic [31:0] src_vector(input int i, input int nsrc);
    if (i == nsrc - 1)
      return NMI_VECTOR;
    else if (i == 0)
      return 32'h0;
    else
      return MSK_VEC_BASE + MSK_VEC_STEP * (i - 1);
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
`timescale 1ns/1ps
module irq_edge_latch (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr,
  output logic pend
);
  logic din_q;
  logic rise;

  assign rise = din & ~din_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      din_q <= din;
      if (rise)
        pend <= 1'b1;
      else if (clr)
        pend <= 1'b0;
    end
  end

  // R4: a pending edge is kept until a clear arrives
  a_r4_latch_holds: assert property (@(posedge clk) disable iff (rst)
    pend && !clr |=> pend);
  // R3: a clear while the input is low leaves nothing pending
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr && !din |=> !pend);
endmodule

// File: rtl/irq_enable_regs.sv
`timescale 1ns/1ps
module irq_enable_regs #(
  parameter int NMSK = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ei,
  input  logic            di,
  input  logic            ack,
  input  logic            msk_wr,
  input  logic [NMSK-1:0] msk_data,
  output logic            ie,
  output logic [NMSK-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie   <= 1'b0;
      mask <= '1;
    end else begin
      if (di || ack)
        ie <= 1'b0;
      else if (ei)
        ie <= 1'b1;
      if (msk_wr)
        mask <= msk_data;
    end
  end

  // R10: any acknowledge leaves the global enable clear
  a_r10_ack_clears_ie: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ie);
  // R7: a mask load takes the supplied bits
  a_r7_mask_load: assert property (@(posedge clk) disable iff (rst)
    msk_wr |=> mask == $past(msk_data));
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int NSRC  = 5,
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             ack,
  input  logic [NSRC-1:0]  req,
  output logic             valid,
  output logic [NSRC-1:0]  src,
  output logic [VEC_W-1:0] vec,
  output logic             has_vec
);
  import irq_pkg::*;

  logic [VEC_W-1:0] vec_tbl [NSRC];
  logic [NSRC-1:0]  win;
  logic [VEC_W-1:0] win_vec;
  logic             win_has_vec;

  for (genvar g = 0; g < NSRC; g++) begin : g_vec
    assign vec_tbl[g] = VEC_W'(src_vector(g, NSRC));
  end

  always_comb begin
    win         = '0;
    win_vec     = '0;
    win_has_vec = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && win == '0) begin
        win[i]      = 1'b1;
        win_vec     = vec_tbl[i];
        win_has_vec = (i != 0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ack) begin
      valid   <= 1'b0;
      src     <= '0;
      vec     <= '0;
      has_vec <= 1'b0;
    end else if (boundary) begin
      valid   <= |req;
      src     <= win;
      vec     <= win_vec;
      has_vec <= win_has_vec;
    end
  end

  // R12: without a strobe or acknowledge the outputs hold
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !boundary && !ack |=> $stable(valid) && $stable(vec) && $stable(src));
  // R11: the general source never reports a vector
  a_r11_gen_no_vec: assert property (@(posedge clk) disable iff (rst)
    valid && src[0] |-> !has_vec && vec == '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
  parameter int NUM_LVL = 2,
  parameter int VEC_W   = 16,
  localparam int NMSK   = NUM_LVL + 1,
  localparam int NSRC   = NUM_LVL + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             nmi_in,
  input  logic             edge_in,
  input  logic [NUM_LVL-1:0] lvl_in,
  input  logic             gen_in,
  input  logic             boundary,
  input  logic             ack,
  input  logic [NSRC-1:0]  ack_sel,
  input  logic             ei_cmd,
  input  logic             di_cmd,
  input  logic             msk_wr,
  input  logic [NMSK-1:0]  msk_data,
  input  logic             msk_clr_edge,
  output logic             irq_valid,
  output logic [NSRC-1:0]  irq_src,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_has_vec,
  output logic             ie_flag
);
  localparam int IDX_NMI  = NSRC - 1;
  localparam int IDX_EDGE = NSRC - 2;

  logic            nmi_pend;
  logic            edge_pend;
  logic            nmi_clr;
  logic            edge_clr;
  logic            ie;
  logic [NMSK-1:0] mask;
  logic [NSRC-1:0] req;

  assign nmi_clr  = ack & ack_sel[IDX_NMI];
  assign edge_clr = (ack & ack_sel[IDX_EDGE]) | (msk_wr & msk_clr_edge);

  irq_edge_latch u_nmi_latch (
    .clk  (clk),
    .rst  (rst),
    .din  (nmi_in),
    .clr  (nmi_clr),
    .pend (nmi_pend)
  );

  irq_edge_latch u_edge_latch (
    .clk  (clk),
    .rst  (rst),
    .din  (edge_in),
    .clr  (edge_clr),
    .pend (edge_pend)
  );

  irq_enable_regs #(.NMSK(NMSK)) u_enable (
    .clk      (clk),
    .rst      (rst),
    .ei       (ei_cmd),
    .di       (di_cmd),
    .ack      (ack),
    .msk_wr   (msk_wr),
    .msk_data (msk_data),
    .ie       (ie),
    .mask     (mask)
  );

  assign req[IDX_NMI]  = nmi_pend & nmi_in;
  assign req[IDX_EDGE] = ie & edge_pend & ~mask[NUM_LVL];
  for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl
    assign req[j + 1] = ie & lvl_in[j] & ~mask[j];
  end
  assign req[0] = ie & gen_in;

  irq_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .ack      (ack),
    .req      (req),
    .valid    (irq_valid),
    .src      (irq_src),
    .vec      (irq_vec),
    .has_vec  (irq_has_vec)
  );

  assign ie_flag = ie;

  // R8: a valid output names exactly one source
  a_r8_one_winner: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $countones(irq_src) == 1);
  // R12: no source is named while the output is invalid
  a_r12_idle_empty: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> irq_src == '0);
  // R3: acknowledge carries a one-hot select
  a_r3_ack_onehot: assert property (@(posedge clk) disable iff (rst)
    ack |-> $onehot0(ack_sel) && ack_sel != '0);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_in = 0, edge_in = 0, gen_in = 0, boundary = 0, ack = 0;
  logic [1:0]  lvl_in = 0;
  logic [4:0]  ack_sel = 0;
  logic        ei_cmd = 0, di_cmd = 0, msk_wr = 0, msk_clr_edge = 0;
  logic [2:0]  msk_data = 0;
  logic        irq_valid, irq_has_vec, ie_flag;
  logic [4:0]  irq_src;
  logic [15:0] irq_vec;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst(rst), .nmi_in(nmi_in), .edge_in(edge_in), .lvl_in(lvl_in),
    .gen_in(gen_in), .boundary(boundary), .ack(ack), .ack_sel(ack_sel),
    .ei_cmd(ei_cmd), .di_cmd(di_cmd), .msk_wr(msk_wr), .msk_data(msk_data),
    .msk_clr_edge(msk_clr_edge), .irq_valid(irq_valid), .irq_src(irq_src),
    .irq_vec(irq_vec), .irq_has_vec(irq_has_vec), .ie_flag(ie_flag)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    nmi_in = 0; edge_in = 0; lvl_in = 0; gen_in = 0; boundary = 0; ack = 0;
    ack_sel = 0; ei_cmd = 0; di_cmd = 0; msk_wr = 0; msk_clr_edge = 0; msk_data = 0;
    rst = 1; step(); step(); rst = 0;
  endtask

  task automatic strobe();
    boundary = 1; step(); boundary = 0;
  endtask

  task automatic do_ack(input logic [4:0] sel);
    ack = 1; ack_sel = sel; step(); ack = 0; ack_sel = 0;
  endtask

  task automatic do_ei();
    ei_cmd = 1; step(); ei_cmd = 0;
  endtask

  task automatic do_di();
    di_cmd = 1; step(); di_cmd = 0;
  endtask

  task automatic set_mask(input logic [2:0] m, input logic clr);
    msk_wr = 1; msk_data = m; msk_clr_edge = clr; step();
    msk_wr = 0; msk_clr_edge = 0;
  endtask

  task automatic expect_out(input logic v, input logic [4:0] s, input logic [15:0] vec,
                            input string tag);
    check(irq_valid, v, {tag, " valid"});
    check(irq_src, s, {tag, " src"});
    if (v) check(irq_vec, vec, {tag, " vec"});
  endtask

  task automatic t_reset_state();
    do_reset();
    check(irq_valid, 0, "R1 valid after reset");
    check(irq_src, 0, "R1 src after reset");
    check(ie_flag, 0, "R1 ie after reset");
    lvl_in = 2'b11; do_ei(); strobe();
    check(irq_valid, 0, "R1 masks set after reset");
  endtask

  task automatic t_nmi_spike();
    do_reset();
    nmi_in = 1; step(); nmi_in = 0; step(); strobe();
    check(irq_valid, 0, "R2 fallen spike ignored");
    nmi_in = 1; step(); strobe();
    expect_out(1, 5'b10000, 16'h0054, "R2 nmi with ie clear");
  endtask

  task automatic t_nmi_rearm();
    do_ack(5'b10000);
    check(irq_valid, 0, "R3 valid dropped after ack");
    strobe();
    check(irq_valid, 0, "R3 held high gives no new request");
    nmi_in = 0; step(); nmi_in = 1; step(); strobe();
    expect_out(1, 5'b10000, 16'h0054, "R3 new edge rearms");
    nmi_in = 0;
  endtask

  task automatic t_edge_latch();
    do_reset(); do_ei(); set_mask(3'b000, 0);
    edge_in = 1; step(); edge_in = 0; step(); step(); strobe();
    expect_out(1, 5'b01000, 16'h003C, "R4 edge remembered");
    do_ack(5'b01000); do_ei(); strobe();
    check(irq_valid, 0, "R4 ack cleared edge latch");
  endtask

  task automatic t_mask_clear();
    do_reset(); do_ei(); set_mask(3'b000, 0);
    edge_in = 1; step(); edge_in = 0; step();
    set_mask(3'b000, 0); strobe();
    expect_out(1, 5'b01000, 16'h003C, "R5 load without clear keeps latch");
    set_mask(3'b000, 1); strobe();
    check(irq_valid, 0, "R5 load with clear empties latch");
  endtask

  task automatic t_level();
    do_reset(); do_ei(); set_mask(3'b000, 0);
    lvl_in = 2'b10; step(); strobe();
    expect_out(1, 5'b00100, 16'h0034, "R6 high level source");
    lvl_in = 2'b00; step(); strobe();
    check(irq_valid, 0, "R6 dropped level not latched");
    lvl_in = 2'b01; strobe();
    expect_out(1, 5'b00010, 16'h002C, "R9 low level source vector");
    lvl_in = 0;
  endtask

  task automatic t_mask_ie();
    do_reset(); lvl_in = 2'b01; set_mask(3'b000, 0); strobe();
    check(irq_valid, 0, "R7 ie clear blocks");
    do_ei(); set_mask(3'b001, 0); strobe();
    check(irq_valid, 0, "R7 mask bit blocks");
    set_mask(3'b110, 0); strobe();
    expect_out(1, 5'b00010, 16'h002C, "R7 unmasked and enabled");
    do_di(); strobe();
    check(irq_valid, 0, "R7 disable blocks");
    lvl_in = 0;
  endtask

  task automatic t_priority();
    do_reset(); do_ei(); set_mask(3'b000, 0);
    lvl_in = 2'b11; gen_in = 1;
    edge_in = 1; step(); edge_in = 0; strobe();
    expect_out(1, 5'b01000, 16'h003C, "R8 edge beats levels");
    do_ack(5'b01000); do_ei(); strobe();
    expect_out(1, 5'b00100, 16'h0034, "R8 high level next");
    lvl_in = 2'b01; strobe();
    expect_out(1, 5'b00010, 16'h002C, "R8 low level next");
    lvl_in = 2'b00; strobe();
    expect_out(1, 5'b00001, 16'h0000, "R8 general last");
    lvl_in = 2'b11; nmi_in = 1; step(); strobe();
    expect_out(1, 5'b10000, 16'h0054, "R9 nmi beats all");
    nmi_in = 0; lvl_in = 0; gen_in = 0;
  endtask

  task automatic t_enable();
    do_reset();
    do_ei(); check(ie_flag, 1, "R10 ei sets");
    do_di(); check(ie_flag, 0, "R10 di clears");
    ei_cmd = 1; di_cmd = 1; step(); ei_cmd = 0; di_cmd = 0;
    check(ie_flag, 0, "R10 di wins over ei");
    ei_cmd = 1; ack = 1; ack_sel = 5'b00001; step();
    ei_cmd = 0; ack = 0; ack_sel = 0;
    check(ie_flag, 0, "R10 ack wins over ei");
    do_ei(); do_ack(5'b00100);
    check(ie_flag, 0, "R10 ack clears");
  endtask

  task automatic t_general();
    do_reset(); gen_in = 1; do_ei(); strobe();
    expect_out(1, 5'b00001, 16'h0000, "R11 general with masks set");
    check(irq_has_vec, 0, "R11 no vector flag");
    set_mask(3'b000, 0); strobe();
    expect_out(1, 5'b00001, 16'h0000, "R11 mask load no effect");
    do_di(); strobe();
    check(irq_valid, 0, "R11 needs ie");
    gen_in = 0;
  endtask

  task automatic t_hold();
    do_reset(); do_ei(); set_mask(3'b000, 0);
    lvl_in = 2'b10; step(); step();
    check(irq_valid, 0, "R12 no update without strobe");
    strobe();
    expect_out(1, 5'b00100, 16'h0034, "R12 loaded at strobe");
    check(irq_has_vec, 1, "R12 vectored source flag");
    lvl_in = 0; step(); step();
    expect_out(1, 5'b00100, 16'h0034, "R12 held between strobes");
    do_ack(5'b00100);
    check(irq_valid, 0, "R12 ack drops valid");
  endtask

  initial begin
    t_reset_state();
    t_nmi_spike();
    t_nmi_rearm();
    t_edge_latch();
    t_mask_clear();
    t_level();
    t_mask_ie();
    t_priority();
    t_enable();
    t_general();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule